// File: doc/BRIEF.md
# PIPE Power-State Sequencer

This block sits on the PHY side of a PIPE link and runs the power-management handshake with the MAC. The MAC presents a 2-bit power-down request. The sequencer moves its power state to match that request after a programmable settle time. It then announces completion with a single-cycle status pulse. The same pulse, together with a 3-bit receive status, reports the result of a receiver-detect operation. The MAC starts that operation through a request line that it shares with loopback.

The analog detect circuit and the clock-stopping hardware are outside the block. They are represented by plain handshake signals: a start level goes out, and a done strobe and a presence flag come back. P3 is the state in which the parallel clock would stop. It is modelled with its own longer settle time, so entering and leaving P3 takes more cycles than other transitions. The block also gates the transmitter's electrical-idle output according to the current power state.

Power-state encoding on both `pwr_req` and `pwr_state`: 00 = P0 (active), 01 = P1 (short recovery), 10 = P2 (longer recovery, low power), 11 = P3 (lowest power).

Top module: `pipe_pwr_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `pwr_state` equals RST_STATE (default 10, P2), `phy_status` is 0 and `rx_status` is 000. The power encoding is 00=P0, 01=P1, 10=P2, 11=P3.
- R2: A `pwr_req` value that differs from `pwr_state` is accepted on the first rising edge at which the sequencer is idle. `pwr_state` takes the new value, and `phy_status` rises, on the TRANS_DLY-th rising edge after the accepting edge.
- R3: A transition into or out of P3 uses P3_DLY in place of TRANS_DLY.
- R4: `phy_status` is high for exactly one cycle per completed operation, and `pwr_state` changes only in a cycle where `phy_status` is high.
- R5: No new operation is accepted while a transition is running or during its status cycle. A request changed during that time is applied on the edge after the status cycle, using the latest request level. A request equal to `pwr_state` produces no pulse.
- R6: When `det_lpbk` is high in P2 or P3, the sequencer is idle and no power change is requested, `det_start` goes high and stays high until `det_done`. On that edge, a one-cycle `phy_status` is issued with `rx_status` = 011 if `det_present` is high, else 000. `pwr_state` does not change.
- R7: Each detect needs `det_lpbk` to have been low since the previous detect began; holding it high starts no second detect.
- R8: In P0, `loopback` follows `det_lpbk` combinationally; in P1, `det_lpbk` causes no `det_start`, no `loopback` and no `phy_status`.
- R9: With LOWPWR_FORCE_IDLE=1 (default), `tx_elec_idle` equals `tx_idle_in` in P0 and is forced to 1 in P1, P2 and P3.
- R10: `rx_status` is 000 in every cycle where `phy_status` is low and in the status cycle of a power transition.
- R11: If a power change and a detect are requested in the same idle cycle, the power change is taken and no detect starts.
- R12: Asserting `rst_n` low in the middle of a transition returns `pwr_state` to RST_STATE at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 2 | Requested power state from the MAC |
| det_lpbk | input | 1 | Detect request in P2/P3, loopback request in P0 |
| tx_idle_in | input | 1 | Electrical-idle request from the MAC |
| det_done | input | 1 | Analog detect circuit finished (strobe) |
| det_present | input | 1 | Analog detect result, valid with det_done |
| pwr_state | output | 2 | Current power state |
| phy_status | output | 1 | One-cycle completion pulse |
| rx_status | output | 3 | Receive status; 011 marks a detected receiver |
| det_start | output | 1 | Level that runs the analog detect circuit |
| loopback | output | 1 | Loopback active |
| tx_elec_idle | output | 1 | Transmitter electrical idle |

## Verification
Several rules are checked on every cycle: the status pulse lasts one cycle, the state moves only with that pulse, the receive status is nonzero only with the pulse, detect runs only in P2/P3, loopback appears only in P0, and idle is forced outside P0. Other properties can only be shown by the bench's scenarios. These are the exact settle latencies for normal and P3 transitions, the hold-and-apply of a request changed mid-transition, the priority of a power change over detect, re-arming of detect, and the reset that takes effect without a clock edge. Random request sequences are compared against latencies that the bench computes itself.

// File: rtl/pipe_pwr_pkg.sv
package pipe_pwr_pkg;

   typedef enum logic [1:0] {
      PS_P0 = 2'b00,
      PS_P1 = 2'b01,
      PS_P2 = 2'b10,
      PS_P3 = 2'b11
   } pstate_e;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_PWR  = 2'b01,
      OP_DET  = 2'b10
   } op_e;

   localparam int RXS_W = 3;
   localparam logic [RXS_W-1:0] RXS_OK  = 3'b000;
   localparam logic [RXS_W-1:0] RXS_DET = 3'b011;

endpackage

// File: rtl/pps_delay.sv
module pps_delay #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] ld_val,
   output logic             expire,
   output logic             busy
);

   logic [CNT_W-1:0] cnt;
   logic             active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (load) begin
         active <= 1'b1;
         cnt    <= ld_val;
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

   assign expire = active && (cnt == '0);
   assign busy   = active;

   // R2/R5: the sequencer must never restart a countdown that is still running
   a_r5_load_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active);

endmodule

// File: rtl/pps_detect.sv
module pps_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic det_req,
   input  logic start,
   input  logic active,
   input  logic det_done,
   input  logic det_present,
   output logic armed,
   output logic det_start,
   output logic finish,
   output logic found
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed <= 1'b1;
      else if (start)    armed <= 1'b0;
      else if (!det_req) armed <= 1'b1;
   end

   assign det_start = active;
   assign finish    = active && det_done;
   assign found     = det_present;

   // R7: a detect may only begin after the request line was seen low
   a_r7_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> armed);

endmodule

// File: rtl/pps_txgate.sv
module pps_txgate
   import pipe_pwr_pkg::*;
#(
   parameter bit LOWPWR_FORCE_IDLE = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  pstate_e state,
   input  logic    idle_in,
   output logic    idle_out
);

   generate
      if (LOWPWR_FORCE_IDLE) begin : g_force_all
         assign idle_out = idle_in || (state != PS_P0);
         // R9: every non-active state keeps the transmitter idle
         a_r9_idle_outside_p0: assert property (@(posedge clk) disable iff (!rst_n)
            (state != PS_P0) |-> idle_out);
      end else begin : g_force_deep
         assign idle_out = idle_in || (state == PS_P2) || (state == PS_P3);
         a_r9_idle_deep_states: assert property (@(posedge clk) disable iff (!rst_n)
            ((state == PS_P2) || (state == PS_P3)) |-> idle_out);
      end
   endgenerate

endmodule

// File: rtl/pipe_pwr_seq.sv
module pipe_pwr_seq
   import pipe_pwr_pkg::*;
#(
   parameter int TRANS_DLY         = 4,
   parameter int P3_DLY            = 12,
   parameter int RST_STATE         = 2,
   parameter bit LOWPWR_FORCE_IDLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pwr_req,
   input  logic       det_lpbk,
   input  logic       tx_idle_in,
   input  logic       det_done,
   input  logic       det_present,
   output logic [1:0] pwr_state,
   output logic       phy_status,
   output logic [2:0] rx_status,
   output logic       det_start,
   output logic       loopback,
   output logic       tx_elec_idle
);

   localparam int MAX_DLY = (P3_DLY > TRANS_DLY) ? P3_DLY : TRANS_DLY;
   localparam int CNT_W   = $clog2(MAX_DLY + 1);
   localparam logic [CNT_W-1:0] TD_M1 = CNT_W'(TRANS_DLY - 1);
   localparam logic [CNT_W-1:0] PD_M1 = CNT_W'(P3_DLY - 1);
   localparam pstate_e RST_PS = pstate_e'(RST_STATE[1:0]);

   if (TRANS_DLY < 1) begin : g_bad_trans
      $error("TRANS_DLY must be at least 1");
   end
   if (P3_DLY < 1) begin : g_bad_p3
      $error("P3_DLY must be at least 1");
   end
   if (RST_STATE < 0 || RST_STATE > 3) begin : g_bad_rst
      $error("RST_STATE must encode a power state 0..3");
   end

   pstate_e          cur, tgt, req;
   op_e              op;
   logic             stat_q;
   logic [RXS_W-1:0] rxs_q;
   logic             idle, pwr_go, det_go, deep;
   logic             expire, dly_busy;
   logic [CNT_W-1:0] ld_val;
   logic             armed, det_finish, det_found, det_active;

   assign req    = pstate_e'(pwr_req);
   assign idle   = (op == OP_IDLE) && !stat_q;
   assign deep   = (cur == PS_P2) || (cur == PS_P3);
   assign pwr_go = idle && (req != cur);
   assign det_go = idle && !pwr_go && det_lpbk && armed && deep;
   assign ld_val = ((cur == PS_P3) || (req == PS_P3)) ? PD_M1 : TD_M1;
   assign det_active = (op == OP_DET);

   pps_delay #(.CNT_W(CNT_W)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (pwr_go),
      .ld_val (ld_val),
      .expire (expire),
      .busy   (dly_busy)
   );

   pps_detect u_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .det_req     (det_lpbk),
      .start       (det_go),
      .active      (det_active),
      .det_done    (det_done),
      .det_present (det_present),
      .armed       (armed),
      .det_start   (det_start),
      .finish      (det_finish),
      .found       (det_found)
   );

   pps_txgate #(.LOWPWR_FORCE_IDLE(LOWPWR_FORCE_IDLE)) u_txgate (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (cur),
      .idle_in  (tx_idle_in),
      .idle_out (tx_elec_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= RST_PS;
         tgt    <= RST_PS;
         op     <= OP_IDLE;
         stat_q <= 1'b0;
         rxs_q  <= RXS_OK;
      end else begin
         stat_q <= 1'b0;
         rxs_q  <= RXS_OK;
         case (op)
            OP_IDLE: begin
               if (pwr_go) begin
                  op  <= OP_PWR;
                  tgt <= req;
               end else if (det_go) begin
                  op  <= OP_DET;
               end
            end
            OP_PWR: begin
               if (expire) begin
                  cur    <= tgt;
                  stat_q <= 1'b1;
                  op     <= OP_IDLE;
               end
            end
            OP_DET: begin
               if (det_finish) begin
                  stat_q <= 1'b1;
                  rxs_q  <= det_found ? RXS_DET : RXS_OK;
                  op     <= OP_IDLE;
               end
            end
            default: op <= OP_IDLE;
         endcase
      end
   end

   assign pwr_state  = cur;
   assign phy_status = stat_q;
   assign rx_status  = rxs_q;
   assign loopback   = (cur == PS_P0) && det_lpbk;

   // R4: completion pulse never lasts two cycles
   a_r4_status_single: assert property (@(posedge clk) disable iff (!rst_n)
      phy_status |=> !phy_status);
   // R4: the state moves only together with the completion pulse
   a_r4_state_with_status: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwr_state) |-> phy_status);
   // R10: a nonzero receive status is only shown during a pulse
   a_r10_rxstat_with_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_status != RXS_OK) |-> phy_status);
   // R6: the analog detect runs only in the deep low-power states
   a_r6_detect_deep_only: assert property (@(posedge clk) disable iff (!rst_n)
      det_start |-> (pwr_state == PS_P2 || pwr_state == PS_P3));
   // R8: loopback only in the active state
   a_r8_loopback_p0: assert property (@(posedge clk) disable iff (!rst_n)
      loopback |-> (pwr_state == PS_P0));
   // R5: counter runs only while a power transition is outstanding
   a_r5_counter_with_op: assert property (@(posedge clk) disable iff (!rst_n)
      dly_busy |-> (op == OP_PWR));

endmodule

// File: tb/pipe_pwr_seq_bench.sv
module pipe_pwr_seq_bench;

   localparam int TD = 4;
   localparam int PD = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pwr_req = 2'b10;
   logic       det_lpbk = 1'b0;
   logic       tx_idle_in = 1'b0;
   logic       det_done = 1'b0;
   logic       det_present = 1'b0;
   logic [1:0] pwr_state;
   logic       phy_status;
   logic [2:0] rx_status;
   logic       det_start;
   logic       loopback;
   logic       tx_elec_idle;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   pipe_pwr_seq #(.TRANS_DLY(TD), .P3_DLY(PD), .RST_STATE(2), .LOWPWR_FORCE_IDLE(1'b1)) u_pipe_pwr_seq (
      .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .det_lpbk(det_lpbk),
      .tx_idle_in(tx_idle_in), .det_done(det_done), .det_present(det_present),
      .pwr_state(pwr_state), .phy_status(phy_status), .rx_status(rx_status),
      .det_start(det_start), .loopback(loopback), .tx_elec_idle(tx_elec_idle)
   );

   function automatic int exp_dly(int from, int to);
      return (from == 3 || to == 3) ? PD : TD;
   endfunction

   function automatic int exp_idle(int st, int in_idle);
      return (st != 0) ? 1 : in_idle;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_status(output int n);
      n = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         n++;
         if (phy_status) break;
      end
   endtask

   task automatic go_state(int tgt, string req);
      int from, n, pulses;
      from = pwr_state;
      pwr_req = 2'(tgt);
      if (from != tgt) begin
         wait_status(n);
         chk(req, "transition latency", n, exp_dly(from, tgt) + 1);
         chk(req, "state after pulse", pwr_state, tgt);
         chk("R10", "rx_status on power pulse", rx_status, 0);
         @(negedge clk);
         chk("R4", "pulse width", phy_status, 0);
      end else begin
         pulses = 0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (phy_status) pulses++;
         end
         chk("R5", "pulses for same-state request", pulses, 0);
      end
   endtask

   task automatic do_detect(bit present, string req);
      int st;
      st = pwr_state;
      det_lpbk = 1'b1;
      @(negedge clk);
      chk(req, "det_start raised", det_start, 1);
      repeat (3) @(negedge clk);
      chk(req, "det_start held", det_start, 1);
      det_present = present;
      det_done = 1'b1;
      @(negedge clk);
      det_done = 1'b0;
      chk(req, "detect pulse", phy_status, 1);
      chk(req, "detect rx_status", rx_status, present ? 3 : 0);
      chk(req, "state kept by detect", pwr_state, st);
      @(negedge clk);
      chk("R4", "detect pulse width", phy_status, 0);
      chk(req, "det_start dropped", det_start, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL R2 watchdog: cycles=%0d expected<%0d", 20000, 20000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int n, cnt;
      void'($urandom(32'h5eed_0123));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset state", pwr_state, 2);
      chk("R1", "reset phy_status", phy_status, 0);
      chk("R1", "reset rx_status", rx_status, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "state after release", pwr_state, 2);
      chk("R9", "idle forced in P2", tx_elec_idle, 1);

      // R6 detect with receiver present, then R7 no retrigger
      do_detect(1'b1, "R6");
      cnt = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (det_start || phy_status) cnt++;
      end
      chk("R7", "held request restarts detect", cnt, 0);
      det_lpbk = 1'b0;
      @(negedge clk);
      do_detect(1'b0, "R6");
      det_lpbk = 1'b0;
      @(negedge clk);

      // R2 normal transition, R9 pass-through, R8 loopback
      go_state(0, "R2");
      tx_idle_in = 1'b0; #1;
      chk("R9", "P0 idle low", tx_elec_idle, 0);
      tx_idle_in = 1'b1; #1;
      chk("R9", "P0 idle high", tx_elec_idle, 1);
      det_lpbk = 1'b1; #1;
      chk("R8", "loopback in P0", loopback, 1);
      repeat (3) @(negedge clk);
      chk("R8", "no detect in P0", det_start, 0);
      det_lpbk = 1'b0; #1;
      chk("R8", "loopback follows request", loopback, 0);
      go_state(0, "R5");

      go_state(1, "R2");
      tx_idle_in = 1'b0; #1;
      chk("R9", "idle forced in P1", tx_elec_idle, 1);
      det_lpbk = 1'b1;
      cnt = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (det_start || loopback || phy_status) cnt++;
      end
      chk("R8", "request ignored in P1", cnt, 0);
      det_lpbk = 1'b0;
      @(negedge clk);

      // R3 P3 entry/exit
      go_state(3, "R3");
      do_detect(1'b1, "R6");
      det_lpbk = 1'b0;
      @(negedge clk);
      go_state(0, "R3");

      // R5 request changed mid-transition
      pwr_req = 2'b10;
      @(negedge clk);
      pwr_req = 2'b01;
      wait_status(n);
      chk("R5", "first latency", n, TD);
      chk("R5", "first target kept", pwr_state, 2);
      wait_status(n);
      chk("R5", "held request gap", n, exp_dly(2, 1) + 2);
      chk("R5", "held request applied", pwr_state, 1);
      @(negedge clk);

      // R11 power change beats detect
      go_state(2, "R2");
      pwr_req = 2'b00;
      det_lpbk = 1'b1;
      wait_status(n);
      chk("R11", "power change latency", n, TD + 1);
      chk("R11", "state after priority", pwr_state, 0);
      chk("R11", "no detect code", rx_status, 0);
      det_lpbk = 1'b0;
      @(negedge clk);

      // R12 async reset mid-transition
      pwr_req = 2'b11;
      repeat (3) @(negedge clk);
      rst_n = 1'b0; #1;
      chk("R12", "async reset state", pwr_state, 2);
      chk("R12", "async reset status", phy_status, 0);
      pwr_req = 2'b10;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12", "state after reset", pwr_state, 2);

      // random sequences
      for (int it = 0; it < 40; it++) begin
         int t;
         t = $urandom_range(3, 0);
         go_state(t, (pwr_state == 3 || t == 3) ? "R3" : "R2");
         tx_idle_in = 1'($urandom_range(1, 0)); #1;
         chk("R9", "random idle gate", tx_elec_idle, exp_idle(pwr_state, tx_idle_in));
         if (pwr_state >= 2 && $urandom_range(1, 0) == 1) begin
            do_detect(1'($urandom_range(1, 0)), "R6");
            det_lpbk = 1'b0;
            @(negedge clk);
         end
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule